// File: doc/BRIEF.md
# Event Interrupt Register Bank

This block is the interrupt front end of a serial-bus master controller. The bus engine raises single-cycle event pulses, one wire per source. Each pulse latches a sticky status bit, and software clears that bit by writing a one to it. A mask decides which latched events may raise the single interrupt line. Software cannot write the mask directly. It sets mask bits through a disable register and clears them through an enable register, and it reads the mask back through a separate read-only view.

There are ten source positions. Bit 8 is reserved and never latches. Five of the sources form an error class, and their latched state drives a separate error summary output. Register access uses a simple strobe interface. A write completes in the cycle its strobe is sampled. Read data appears one cycle after the read strobe.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset, status reads 0x000, the mask view reads 0x2FF (every source masked), and irq_out and err_out are low.
- R2: An event pulse on bit position b (0 completion, 1 data, 2 NACK, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost) sets status bit b at the next clock edge. The bit stays set until it is cleared.
- R3: A write to offset 0x10 clears each status bit whose written bit is one. Zero bits leave their status bits unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x24 unmasks each source whose written bit is one. Zero bits leave the mask unchanged.
- R6: A write to offset 0x28 masks each source whose written bit is one. Zero bits leave the mask unchanged, and writing 0x2FF masks every source.
- R7: A read of offset 0x20 returns the mask with the same bit layout as status, where 1 means masked. A read of 0x10 returns status. The data appears on rdata in the cycle after rd_en is sampled.
- R8: irq_out is high in cycle t+1 exactly when some status bit is set and unmasked in cycle t.
- R9: err_out is high in cycle t+1 exactly when any status bit in the error class (bits 9, 7, 6, 5 and 2) is set in cycle t, whatever the mask holds.
- R10: Reads of offsets 0x24 and 0x28, and of any unmapped offset, return zero.
- R11: Bit 8 is reserved. Events and writes on it have no effect, and it reads as zero in both status and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| evt_pulse | input | 10 | Per-source event pulses from the bus engine |
| irq_out | output | 1 | Registered interrupt request |
| err_out | output | 1 | Registered error-class summary |

## Verification
Two functions can fall in the same cycle: an event from the bus engine and a software clear of the same status bit. The bench provokes this collision on purpose, first with the same bit in both and then with neighbouring bits. It also forces the collision many times through random traffic, where pulses arrive during clear writes. A behavioural model compares rdata, irq_out and err_out on every clock and decides each outcome. After such a collision, a later read must show the event bit set and the other cleared bits gone.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   // read-path selector produced by the decoder
   typedef enum logic [1:0] {
      RS_NONE = 2'd0,
      RS_STAT = 2'd1,
      RS_MASK = 2'd2
   } rsel_e;

   localparam int DEF_OFS_STAT = 'h10;
   localparam int DEF_OFS_VIEW = 'h20;
   localparam int DEF_OFS_EN   = 'h24;
   localparam int DEF_OFS_DIS  = 'h28;
endpackage

// File: rtl/irq_decode.sv
module irq_decode
   import evt_irq_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFS_STAT = DEF_OFS_STAT,
   parameter int OFS_VIEW = DEF_OFS_VIEW,
   parameter int OFS_EN   = DEF_OFS_EN,
   parameter int OFS_DIS  = DEF_OFS_DIS
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              clr_stb,
   output logic              en_stb,
   output logic              dis_stb,
   output rsel_e             rd_sel
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_VIEW = ADDR_W'(OFS_VIEW);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
   localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);

   always_comb begin
      clr_stb = wr_en && (addr == A_STAT);
      en_stb  = wr_en && (addr == A_EN);
      dis_stb = wr_en && (addr == A_DIS);
      rd_sel  = RS_NONE;
      if (rd_en) begin
         if (addr == A_STAT)      rd_sel = RS_STAT;
         else if (addr == A_VIEW) rd_sel = RS_MASK;
      end
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int                  NUM_SRC = 10,
   parameter logic [NUM_SRC-1:0] VALID   = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               clr_stb,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] status_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (VALID[i]) begin : g_live
         logic nxt;
         // an arriving event wins over a clear of the same bit
         always_comb nxt = evt[i] | (status_q[i] & ~(clr_stb & wbits[i]));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_q[i] <= 1'b0;
            else        status_q[i] <= nxt;
         end
      end else begin : g_rsvd
         assign status_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int                  NUM_SRC = 10,
   parameter logic [NUM_SRC-1:0] VALID   = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_stb,
   input  logic               dis_stb,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] mask_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (VALID[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      mask_q[i] <= 1'b1;
            else if (dis_stb && wbits[i])    mask_q[i] <= 1'b1;
            else if (en_stb && wbits[i])     mask_q[i] <= 1'b0;
         end
      end else begin : g_rsvd
         assign mask_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
   import evt_irq_pkg::*;
#(
   parameter int                  NUM_SRC = 10,
   parameter logic [NUM_SRC-1:0] ERR_MAP = '0,
   parameter bit                  REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_q,
   input  logic [NUM_SRC-1:0] mask_q,
   input  rsel_e              rd_sel,
   output logic [NUM_SRC-1:0] rd_q,
   output logic               irq_out,
   output logic               err_out
);
   logic irq_d, err_d;
   logic [NUM_SRC-1:0] rd_d;

   always_comb begin
      irq_d = |(status_q & ~mask_q);
      err_d = |(status_q & ERR_MAP);
      unique case (rd_sel)
         RS_STAT: rd_d = status_q;
         RS_MASK: rd_d = mask_q;
         default: rd_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_out <= 1'b0;
            err_out <= 1'b0;
         end else begin
            irq_out <= irq_d;
            err_out <= err_d;
         end
      end
   end else begin : g_comb
      assign irq_out = irq_d;
      assign err_out = err_d;
   end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
   import evt_irq_pkg::*;
#(
   parameter int                  ADDR_W   = 8,
   parameter int                  DATA_W   = 32,
   parameter int                  NUM_SRC  = 10,
   parameter logic [NUM_SRC-1:0] RSVD_MAP = 10'h100,
   parameter logic [NUM_SRC-1:0] ERR_MAP  = 10'h2E4,
   parameter int                  OFS_STAT = DEF_OFS_STAT,
   parameter int                  OFS_VIEW = DEF_OFS_VIEW,
   parameter int                  OFS_EN   = DEF_OFS_EN,
   parameter int                  OFS_DIS  = DEF_OFS_DIS,
   parameter bit                  REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NUM_SRC-1:0] evt_pulse,
   output logic              irq_out,
   output logic              err_out
);
   localparam logic [NUM_SRC-1:0] VALID = ~RSVD_MAP;

   // elaboration-time parameter checks
   if (NUM_SRC > DATA_W) begin : g_chk_w
      $error("evt_irq_regs: NUM_SRC exceeds DATA_W");
   end
   if ((ERR_MAP & RSVD_MAP) != '0) begin : g_chk_err
      $error("evt_irq_regs: error class overlaps reserved bits");
   end
   if (OFS_STAT == OFS_EN || OFS_STAT == OFS_DIS || OFS_EN == OFS_DIS ||
       OFS_VIEW == OFS_STAT || OFS_VIEW == OFS_EN || OFS_VIEW == OFS_DIS) begin : g_chk_ofs
      $error("evt_irq_regs: register offsets collide");
   end
   if (OFS_DIS >= (1 << ADDR_W) || OFS_EN >= (1 << ADDR_W) ||
       OFS_STAT >= (1 << ADDR_W) || OFS_VIEW >= (1 << ADDR_W)) begin : g_chk_aw
      $error("evt_irq_regs: offset does not fit ADDR_W");
   end

   logic               clr_stb, en_stb, dis_stb;
   rsel_e              rd_sel;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] status_q, mask_q, rd_q;
   logic               unused_wdata_hi;

   assign wbits           = wdata[NUM_SRC-1:0];
   assign unused_wdata_hi = ^wdata;
   assign rdata           = DATA_W'(rd_q);

   irq_decode #(
      .ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT), .OFS_VIEW(OFS_VIEW),
      .OFS_EN(OFS_EN), .OFS_DIS(OFS_DIS)
   ) u_dec (
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .clr_stb(clr_stb), .en_stb(en_stb), .dis_stb(dis_stb), .rd_sel(rd_sel)
   );

   irq_status_bank #(.NUM_SRC(NUM_SRC), .VALID(VALID)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr_stb(clr_stb),
      .wbits(wbits), .status_q(status_q)
   );

   irq_mask_bank #(.NUM_SRC(NUM_SRC), .VALID(VALID)) u_mask (
      .clk(clk), .rst_n(rst_n), .en_stb(en_stb), .dis_stb(dis_stb),
      .wbits(wbits), .mask_q(mask_q)
   );

   irq_out_stage #(.NUM_SRC(NUM_SRC), .ERR_MAP(ERR_MAP), .REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n), .status_q(status_q), .mask_q(mask_q),
      .rd_sel(rd_sel), .rd_q(rd_q), .irq_out(irq_out), .err_out(err_out)
   );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
   parameter int                  ADDR_W   = 8,
   parameter int                  DATA_W   = 32,
   parameter int                  NUM_SRC  = 10,
   parameter logic [NUM_SRC-1:0] VALID    = '1,
   parameter logic [NUM_SRC-1:0] ERR_MAP  = '0,
   parameter int                  OFS_STAT = 'h10,
   parameter int                  OFS_EN   = 'h24,
   parameter int                  OFS_DIS  = 'h28
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [DATA_W-1:0]  wdata,
   input logic [DATA_W-1:0]  rdata,
   input logic [NUM_SRC-1:0] evt_pulse,
   input logic               irq_out,
   input logic               err_out,
   input logic [NUM_SRC-1:0] status_q,
   input logic [NUM_SRC-1:0] mask_q
);
   // R2 R4
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_pulse & VALID) != '0) |=>
      ((status_q & $past(evt_pulse & VALID)) == $past(evt_pulse & VALID)));

   // R3
   clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_STAT)) |=>
      ((status_q & $past(wdata[NUM_SRC-1:0] & ~evt_pulse)) == '0));

   // R5
   enable_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_EN)) |=>
      ((mask_q & $past(wdata[NUM_SRC-1:0] & VALID)) == '0));

   // R6
   disable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_DIS)) |=>
      ((mask_q & $past(wdata[NUM_SRC-1:0] & VALID)) == $past(wdata[NUM_SRC-1:0] & VALID)));

   // R8
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == $past(|(status_q & ~mask_q)));

   // R9
   err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_out == $past(|(status_q & ERR_MAP)));

   // R10
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == ADDR_W'(OFS_EN) || addr == ADDR_W'(OFS_DIS))) |=> (rdata == '0));

   // R11
   rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~VALID) == '0) && ((mask_q & ~VALID) == '0));
endmodule

bind evt_irq_regs evt_irq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .VALID(VALID),
   .ERR_MAP(ERR_MAP), .OFS_STAT(OFS_STAT), .OFS_EN(OFS_EN), .OFS_DIS(OFS_DIS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .irq_out(irq_out),
   .err_out(err_out), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/sim_evt_irq_regs.sv
`timescale 1ns/1ps
module sim_evt_irq_regs;
   localparam int VALID = 'h2FF;
   localparam int ERRS  = 'h2E4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [9:0]  evt_pulse = '0;
   logic        irq_out, err_out;

   int    n_cmp = 0, n_bad = 0, wd = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // model state
   int m_status, m_mask, m_rdata;
   bit m_irq, m_err;

   always #4 clk = ~clk;

   evt_irq_regs u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse),
      .irq_out(irq_out), .err_out(err_out)
   );

   // behavioural reference, evaluated at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_status = 0; m_mask = VALID; m_rdata = 0; m_irq = 0; m_err = 0;
      end else begin
         int clr;
         m_rdata = 0;
         if (rd_en) begin
            if (addr == 8'h10)      m_rdata = m_status;
            else if (addr == 8'h20) m_rdata = m_mask;
         end
         m_irq = (m_status & ~m_mask) != 0;
         m_err = (m_status & ERRS) != 0;
         clr = (wr_en && addr == 8'h10) ? (int'(wdata) & VALID) : 0;
         m_status = (m_status & ~clr) | (int'(evt_pulse) & VALID);
         if (wr_en && addr == 8'h24) m_mask = m_mask & ~(int'(wdata) & VALID);
         if (wr_en && addr == 8'h28) m_mask = m_mask | (int'(wdata) & VALID);
      end
   end

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp += 3;
         if (rdata !== 32'(m_rdata)) begin
            n_bad++;
            $display("FAIL %s rdata act=%h exp=%h", cur_req, rdata, 32'(m_rdata));
         end
         if (irq_out !== m_irq) begin
            n_bad++;
            $display("FAIL R8 irq_out act=%b exp=%b", irq_out, m_irq);
         end
         if (err_out !== m_err) begin
            n_bad++;
            $display("FAIL R9 err_out act=%b exp=%b", err_out, m_err);
         end
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 20000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog act=%0d exp<=20000", wd);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic op(input bit w, input bit r, input logic [7:0] a,
                     input logic [31:0] d, input logic [9:0] e);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d; evt_pulse = e;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(0, 0, 8'h00, 32'h0, 10'h0);
   endtask

   task automatic rd(input logic [7:0] a);
      op(0, 1, a, 32'h0, 10'h0);
      idle(1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cur_req = "R1";
      rd(8'h10); rd(8'h20);
      if (rdata !== 32'h0) begin end
      // R2 each source in turn, R11 the reserved position
      for (int b = 0; b < 10; b++) begin
         cur_req = (b == 8) ? "R11" : "R2";
         op(0, 0, 8'h00, 32'h0, 10'(1 << b));
         rd(8'h10);
      end
      // R5 unmask completion and R7 view, R8 interrupt rises
      cur_req = "R5";
      op(1, 0, 8'h24, 32'h001, 10'h0); idle(2);
      cur_req = "R7";
      rd(8'h20);
      // R3 partial clear, then zeros do nothing
      cur_req = "R3";
      op(1, 0, 8'h10, 32'h0F0, 10'h0); rd(8'h10);
      op(1, 0, 8'h10, 32'h000, 10'h0); rd(8'h10);
      // R4 collision on the same bit, then neighbouring bits
      cur_req = "R4";
      op(1, 0, 8'h10, 32'h004, 10'h004); rd(8'h10);
      op(1, 0, 8'h10, 32'h003, 10'h002); rd(8'h10);
      // R6 mask everything, interrupt must fall
      cur_req = "R6";
      op(1, 0, 8'h28, 32'h2FF, 10'h0); idle(2); rd(8'h20);
      op(1, 0, 8'h24, 32'h3FF, 10'h0); rd(8'h20);
      op(1, 0, 8'h28, 32'h000, 10'h0); rd(8'h20);
      // R10 write-only and unmapped reads
      cur_req = "R10";
      rd(8'h24); rd(8'h28); rd(8'h3C); rd(8'h14);
      // R9 error summary independent of mask
      cur_req = "R9";
      op(1, 0, 8'h28, 32'h2FF, 10'h0);
      op(1, 0, 8'h10, 32'h3FF, 10'h0); idle(2);
      op(0, 0, 8'h00, 32'h0, 10'h001); idle(2);
      op(0, 0, 8'h00, 32'h0, 10'h040); idle(2); rd(8'h10);
      op(1, 0, 8'h10, 32'h040, 10'h0); idle(2);
      // R11 reserved writes
      cur_req = "R11";
      op(1, 0, 8'h24, 32'h100, 10'h100); rd(8'h20); rd(8'h10);
      // random traffic with collisions
      cur_req = "R4";
      for (int i = 0; i < 600; i++) begin
         logic [7:0] a;
         int sel = $urandom % 5;
         a = (sel == 0) ? 8'h10 : (sel == 1) ? 8'h20 : (sel == 2) ? 8'h24 :
             (sel == 3) ? 8'h28 : 8'h14;
         op(($urandom % 3) == 0, ($urandom % 2) == 0, a, $urandom,
            (($urandom % 4) == 0) ? 10'($urandom) : 10'h0);
      end
      idle(3);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule